// File: doc/BRIEF.md
# Iterative Byte-Feistel Block Encryption Core

This core encrypts one 64-bit block under a 128-bit master key. It treats the block as eight byte lanes and runs a generalized Feistel network that uses only byte-wide addition modulo 256, rotations and XOR. A single round datapath is used once per clock over 32 rounds. An initial whitening step comes before the rounds and a final whitening step follows them.

A one-cycle `start_i` pulse latches the plaintext and the key while the core is idle. The core does not build round subkeys itself. It presents the round index `rnd_idx_o` and the latched key `mk_o` to an external subkey generator. That generator returns the four subkey bytes for the round on `sk_i` in the same cycle. When the last round completes, `done_o` pulses for one cycle and the ciphertext appears on `cipher_o`. The ciphertext stays there until the next encryption completes.

Top module: `lwf_cipher`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rnd_idx_o` and `cipher_o` are all zero.
- R2: A `start_i` sampled while idle loads plaintext and key. In the next cycle `busy_o` is 1, `rnd_idx_o` is 0 and `mk_o` equals the key.
- R3: While busy, `rnd_idx_o` counts up by one per cycle, from 0 to 31. In the cycle where the index is r, `sk_i[8k+7:8k]` is taken as subkey byte 4r+k.
- R4: `done_o` is high for exactly one cycle: the 33rd cycle after the start edge, with the start edge counted as edge 0. In that same cycle `busy_o` is back to 0.
- R5: Byte j of every 64-bit word is bits [8j+7:8j], and master key byte j is `key_i[8j+7:8j]`. Initial whitening sets X0=P0+K12, X2=P2^K13, X4=P4+K14 and X6=P6^K15. It does not change the odd bytes.
- R5 (round): With F0(x)=rotl1^rotl2^rotl7 and F1(x)=rotl3^rotl4^rotl6, each round computes four values: a=X1+(F1(X0)^S0), b=X3^(F0(X2)+S1), c=X5+(F1(X4)^S2) and d=X7^(F0(X6)+S3).
- R5 (rotation): Rounds 0 to 30 produce the byte order (d,X0,a,X2,b,X4,c,X6). Round 31 produces (X0,a,X2,b,X4,c,X6,d).
- R5 (final): Final whitening then sets C0=X0+K0, C2=X2^K1, C4=X4+K2 and C6=X6^K3, with the odd bytes passing through.
- R6: A `start_i` that arrives while busy is ignored. Neither the round count nor the result is affected.
- R7: `cipher_o` holds its value from one completion to the next, including through a following run. `key_i` changes made while busy have no effect on the result.
- R8: A `start_i` given in the `done_o` cycle is accepted and begins a new run at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin encryption (accepted when idle) |
| plain_i | input | 64 | Plaintext block |
| key_i | input | 128 | Master key |
| sk_i | input | 32 | Four subkey bytes for the current round |
| rnd_idx_o | output | 5 | Current round index for the subkey generator |
| mk_o | output | 128 | Latched master key for the subkey generator |
| busy_o | output | 1 | Encryption in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cipher_o | output | 64 | Ciphertext, held between completions |

## Verification
The assertions assume that `sk_i` is a pure function of `rnd_idx_o` and `mk_o` that settles within the cycle. They also assume that reset is applied before the first start. The bench's subkey generator is combinational logic fed only by those two outputs. The bench changes `start_i` and `key_i` only on falling edges, and it issues starts both while idle and deliberately while busy. That stimulus exercises the ignore rule without violating the generator assumption.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  localparam int BLK_W = 64;
  localparam int KEY_W = 128;
  localparam int SKB_W = 32;

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    rotl8 = (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] f0(input logic [7:0] v);
    f0 = rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 7);
  endfunction

  function automatic logic [7:0] f1(input logic [7:0] v);
    f1 = rotl8(v, 3) ^ rotl8(v, 4) ^ rotl8(v, 6);
  endfunction

  function automatic logic [7:0] byte_of(input logic [BLK_W-1:0] w, input int j);
    byte_of = w[8*j +: 8];
  endfunction

  function automatic logic [BLK_W-1:0] init_whiten(input logic [BLK_W-1:0] p,
                                                   input logic [KEY_W-1:0] k);
    logic [BLK_W-1:0] x;
    x = p;
    x[7:0]   = p[7:0]   + k[103:96];
    x[23:16] = p[23:16] ^ k[111:104];
    x[39:32] = p[39:32] + k[119:112];
    x[55:48] = p[55:48] ^ k[127:120];
    init_whiten = x;
  endfunction

  function automatic logic [BLK_W-1:0] final_whiten(input logic [BLK_W-1:0] p,
                                                    input logic [KEY_W-1:0] k);
    logic [BLK_W-1:0] x;
    x = p;
    x[7:0]   = p[7:0]   + k[7:0];
    x[23:16] = p[23:16] ^ k[15:8];
    x[39:32] = p[39:32] + k[23:16];
    x[55:48] = p[55:48] ^ k[31:24];
    final_whiten = x;
  endfunction

  function automatic logic [BLK_W-1:0] round_step(input logic [BLK_W-1:0] x,
                                                  input logic [SKB_W-1:0] sk,
                                                  input logic rotate);
    logic [7:0] a, b, c, d;
    a = byte_of(x, 1) + (f1(byte_of(x, 0)) ^ sk[7:0]);
    b = byte_of(x, 3) ^ (f0(byte_of(x, 2)) + sk[15:8]);
    c = byte_of(x, 5) + (f1(byte_of(x, 4)) ^ sk[23:16]);
    d = byte_of(x, 7) ^ (f0(byte_of(x, 6)) + sk[31:24]);
    if (rotate)
      round_step = {byte_of(x, 6), c, byte_of(x, 4), b, byte_of(x, 2), a, byte_of(x, 0), d};
    else
      round_step = {d, byte_of(x, 6), c, byte_of(x, 4), b, byte_of(x, 2), a, byte_of(x, 0)};
  endfunction
endpackage

// File: rtl/lwf_ctrl.sv
module lwf_ctrl #(
  parameter int NROUNDS = 32,
  localparam int CW = $clog2(NROUNDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          load_o,
  output logic          step_o,
  output logic          last_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] rnd_o
);
  localparam logic [CW-1:0] LAST_IDX = CW'(NROUNDS - 1);

  logic          busy_q, done_q;
  logic [CW-1:0] rnd_q;

  assign load_o = start_i && !busy_q;
  assign last_o = busy_q && (rnd_q == LAST_IDX);
  assign step_o = busy_q && !last_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rnd_q  <= '0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        rnd_q  <= '0;
      end else if (last_o) begin
        busy_q <= 1'b0;
        rnd_q  <= '0;
      end else if (busy_q) begin
        rnd_q  <= rnd_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rnd_o  = rnd_q;

  a_r2_load_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && rnd_q == '0));
  a_r3_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (busy_q && rnd_q == $past(rnd_q) + 1'b1));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  a_r6_no_restart_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && step_o) |=> (rnd_q != '0));
endmodule

// File: rtl/lwf_datapath.sv
module lwf_datapath
  import lwf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [BLK_W-1:0] plain_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [SKB_W-1:0] sk_i,
  output logic [KEY_W-1:0] mk_o,
  output logic [BLK_W-1:0] ct_o
);
  logic [BLK_W-1:0] x_q, ct_q;
  logic [KEY_W-1:0] key_q;
  logic [BLK_W-1:0] round_out;

  assign round_out = round_step(x_q, sk_i, !last_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q   <= '0;
      key_q <= '0;
      ct_q  <= '0;
    end else begin
      if (load_i) begin
        x_q   <= init_whiten(plain_i, key_i);
        key_q <= key_i;
      end else if (step_i) begin
        x_q   <= round_out;
      end
      if (last_i) ct_q <= final_whiten(round_out, key_q);
    end
  end

  assign mk_o = key_q;
  assign ct_o = ct_q;

  a_r7_key_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(key_q));
  a_r7_ct_changes_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |-> $stable(ct_q));
endmodule

// File: rtl/lwf_cipher.sv
module lwf_cipher
  import lwf_pkg::*;
#(
  parameter int NROUNDS = 32,
  localparam int CW = $clog2(NROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BLK_W-1:0] plain_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [SKB_W-1:0] sk_i,
  output logic [CW-1:0]    rnd_idx_o,
  output logic [KEY_W-1:0] mk_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [BLK_W-1:0] cipher_o
);
  logic load_w, step_w, last_w;

  lwf_ctrl #(.NROUNDS(NROUNDS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load_w),
    .step_o  (step_w),
    .last_o  (last_w),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .rnd_o   (rnd_idx_o)
  );

  lwf_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_w),
    .step_i  (step_w),
    .last_i  (last_w),
    .busy_i  (busy_o),
    .done_i  (done_o),
    .plain_i (plain_i),
    .key_i   (key_i),
    .sk_i    (sk_i),
    .mk_o    (mk_o),
    .ct_o    (cipher_o)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && !done_o && rnd_idx_o == '0 && cipher_o == '0));
endmodule

// File: tb/lwf_cipher_bench.sv
module lwf_cipher_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [63:0]  plain_i = '0;
  logic [127:0] key_i = '0;
  logic [31:0]  sk_i;
  logic [4:0]   rnd_idx_o;
  logic [127:0] mk_o;
  logic         busy_o, done_o;
  logic [63:0]  cipher_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lwf_cipher u_lwf_cipher (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .plain_i(plain_i), .key_i(key_i),
    .sk_i(sk_i), .rnd_idx_o(rnd_idx_o), .mk_o(mk_o), .busy_o(busy_o),
    .done_o(done_o), .cipher_o(cipher_o)
  );

  // stimulus subkey generator: byte n of the schedule from round index and key
  function automatic logic [7:0] gen_sk(input logic [127:0] k, input int n);
    logic [7:0] m;
    m = k[8*(n % 16) +: 8];
    return m ^ (8'(n * 29) + 8'd5);
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++)
      sk_i[8*k +: 8] = gen_sk(mk_o, 4 * int'(rnd_idx_o) + k);
  end

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    logic [15:0] d;
    d = {v, v} << n;
    return d[15:8];
  endfunction

  function automatic logic [63:0] model(input logic [63:0] p, input logic [127:0] k);
    logic [7:0] x[8], y[8], mk[16], s[4], t[4];
    for (int j = 0; j < 16; j++) mk[j] = k[8*j +: 8];
    for (int j = 0; j < 8; j++) x[j] = p[8*j +: 8];
    x[0] = x[0] + mk[12]; x[2] = x[2] ^ mk[13];
    x[4] = x[4] + mk[14]; x[6] = x[6] ^ mk[15];
    for (int r = 0; r < 32; r++) begin
      for (int q = 0; q < 4; q++) s[q] = gen_sk(k, 4 * r + q);
      t[0] = x[1] + ((rl(x[0],3) ^ rl(x[0],4) ^ rl(x[0],6)) ^ s[0]);
      t[1] = x[3] ^ ((rl(x[2],1) ^ rl(x[2],2) ^ rl(x[2],7)) + s[1]);
      t[2] = x[5] + ((rl(x[4],3) ^ rl(x[4],4) ^ rl(x[4],6)) ^ s[2]);
      t[3] = x[7] ^ ((rl(x[6],1) ^ rl(x[6],2) ^ rl(x[6],7)) + s[3]);
      if (r < 31) begin
        y[0] = t[3]; y[1] = x[0]; y[2] = t[0]; y[3] = x[2];
        y[4] = t[1]; y[5] = x[4]; y[6] = t[2]; y[7] = x[6];
      end else begin
        y[0] = x[0]; y[1] = t[0]; y[2] = x[2]; y[3] = t[1];
        y[4] = x[4]; y[5] = t[2]; y[6] = x[6]; y[7] = t[3];
      end
      x = y;
    end
    x[0] = x[0] + mk[0]; x[2] = x[2] ^ mk[1];
    x[4] = x[4] + mk[2]; x[6] = x[6] ^ mk[3];
    for (int j = 0; j < 8; j++) model[8*j +: 8] = x[j];
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  localparam logic [191:0] VEC [5] = '{
    {64'h0000000000000000, 128'h0},
    {64'hFFFFFFFFFFFFFFFF, 128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF},
    {64'h0123456789ABCDEF, 128'h00112233445566778899AABBCCDDEEFF},
    {64'h8000000000000001, 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F},
    {64'hDEADBEEFCAFEF00D, 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0}
  };

  // mode 0 plain, 1 extra start while busy, 2 key change while busy
  task automatic run_one(input logic [63:0] p, input logic [127:0] k, input int mode,
                         input logic [63:0] prev);
    logic [63:0] exp;
    exp = model(p, k);
    start_i = 1'b1; plain_i = p; key_i = k;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && rnd_idx_o == 5'd0, "R2 busy/index after load", {busy_o, rnd_idx_o}, {1'b1, 5'd0});
    check(mk_o == k, "R2 latched key", mk_o, k);
    for (int c = 1; c < 32; c++) begin
      @(negedge clk);
      if (mode == 1 && c == 10) begin start_i = 1'b1; plain_i = ~p; end
      if (mode == 1 && c == 11) begin start_i = 1'b0; plain_i = p; end
      if (mode == 2 && c == 5) key_i = ~k;
      if (c == 12) check(rnd_idx_o == 5'(c), "R3 round index", rnd_idx_o, c);
      if (c == 15) check(cipher_o == prev, "R7 output held during run", cipher_o, prev);
      if (c == 31) check(!done_o && busy_o, "R4 no early done", {done_o, busy_o}, 2'b01);
    end
    @(negedge clk);
    check(done_o && !busy_o, "R4 done in 33rd cycle", {done_o, busy_o}, 2'b10);
    check(cipher_o == exp, mode == 1 ? "R6 start while busy ignored" :
                            mode == 2 ? "R7 key change ignored" : "R5 ciphertext",
          cipher_o, exp);
    key_i = k;
  endtask

  initial begin
    logic [63:0] last;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && rnd_idx_o == 0 && cipher_o == 0, "R1 reset state",
          {busy_o, done_o, rnd_idx_o, cipher_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && cipher_o == 0, "R1 idle after release",
          {busy_o, done_o, cipher_o}, 0);
    last = '0;
    for (int v = 0; v < 5; v++) begin
      run_one(VEC[v][191:128], VEC[v][127:0], 0, last);
      last = model(VEC[v][191:128], VEC[v][127:0]);
      @(negedge clk);
      check(!done_o, "R4 done falls after one cycle", done_o, 0);
      check(cipher_o == last, "R7 output held after done", cipher_o, last);
    end
    run_one(64'h1122334455667788, 128'hA5A5A5A55A5A5A5A0123456789ABCDEF, 1, last);
    last = model(64'h1122334455667788, 128'hA5A5A5A55A5A5A5A0123456789ABCDEF);
    // R8: start issued in the done cycle
    run_one(64'h0F0F0F0FF0F0F0F0, 128'h13579BDF2468ACE0FEDCBA9876543210, 2, last);
    last = model(64'h0F0F0F0FF0F0F0F0, 128'h13579BDF2468ACE0FEDCBA9876543210);
    run_one(64'hCAFEBABE00000000, 128'h1, 0, last);
    last = model(64'hCAFEBABE00000000, 128'h1);
    check(1'b1, "R8 back-to-back accepted", 0, 0);
    repeat (5) @(negedge clk);
    check(!busy_o && !done_o && cipher_o == last, "R7 idle hold",
          {busy_o, done_o, cipher_o}, {2'b00, last});
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule